// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is a SIMD arithmetic datapath. It treats each 32-bit lane of two source vectors as four packed bytes. It multiplies each byte of the first source by the byte in the same position of the second source and adds the four products together. The resulting dot product is added to the same lane of an incoming accumulator vector. The updated lanes come back on the result port one clock later, together with a valid strobe.

A single control bit chooses how the bytes are read: as two's-complement signed values or as unsigned magnitudes. A width control chooses one of two operation sizes. The narrow operation touches only the low 64 bits, which is two lanes. The wide operation covers all 128 bits, which is four lanes. The wide operation works on register pairs, so the caller also supplies the lowest index bit of the destination register and of both source registers. A wide request that names any odd register is refused: the block raises an illegal flag instead of producing a result.

Top module: `byte_dot_acc`

## Requirements
- R1: Result lane e (bits 32e+31..32e) equals accumulator lane e plus the sum of the four products of source bytes 4e..4e+3 (byte k at bits 8k+7..8k), each byte of the first source multiplied by the byte of the second source at the same position.
- R2: With `is_unsigned`=0 every byte is a two's-complement value in -128..127. With `is_unsigned`=1 every byte is a value in 0..255.
- R3: The lane addition wraps modulo 2^32. There is no saturation and no overflow indication.
- R4: With `wide_mode`=0 only lanes 0 and 1 are computed, and result bits 127..64 are zero.
- R5: With `wide_mode`=1 all four lanes are computed.
- R6: A request with `wide_mode`=1 and any of `dst_idx_lsb`, `srca_idx_lsb`, `srcb_idx_lsb` equal to 1 raises `illegal` for exactly one cycle, in the cycle after the request.
- R7: An illegal request leaves `out_valid` low and leaves `result` at its previous value.
- R8: A legal request produces its result and `out_valid`=1 in the cycle after `in_valid`. When no request is presented, `out_valid` and `illegal` are low in the next cycle and `result` keeps its value.
- R9: With `wide_mode`=0 the index low bits are ignored: the request is legal for every combination of them.
- R10: During and right after reset, `out_valid`=0, `illegal`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| is_unsigned | input | 1 | 1: bytes unsigned, 0: bytes signed |
| wide_mode | input | 1 | 1: 128-bit operation, 0: 64-bit operation |
| dst_idx_lsb | input | 1 | Lowest bit of destination register index |
| srca_idx_lsb | input | 1 | Lowest bit of first source register index |
| srcb_idx_lsb | input | 1 | Lowest bit of second source register index |
| src_a | input | 128 | First packed-byte source vector |
| src_b | input | 128 | Second packed-byte source vector |
| acc_in | input | 128 | Accumulator vector, four 32-bit lanes |
| out_valid | output | 1 | Result valid, one cycle after a legal request |
| illegal | output | 1 | Refused-request flag, one cycle after the request |
| result | output | 128 | Updated accumulator lanes |

## Verification
The hardest case to reach is the sign-extension boundary of the byte products. Only a few byte values, such as 0x80 paired with 0x80 or 0xFF paired with 0xFF, expose an error in the choice between sign and zero extension. The lane wrap also needs a dot product added to an accumulator near 2^31 or 2^32. The stimulus therefore sweeps every first-source byte value against a stride of second-source values in both sign modes, with each lane's bytes permuted so that every byte position carries the extremes. It then adds fixed cases with all bytes at 0x80 or 0xFF on accumulators of 0x7FFFFFFF and 0xFFFFFFFF, and walks all index-bit combinations in both width modes.

// File: rtl/dp_pkg.sv
package dp_pkg;

   typedef enum logic {
      DP_SIGNED   = 1'b0,
      DP_UNSIGNED = 1'b1
   } dp_sign_e;

   typedef struct packed {
      logic dst;
      logic srca;
      logic srcb;
   } dp_idx_lsb_t;

   function automatic int unsigned dp_log2up(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/dp_elem_mul.sv
module dp_elem_mul #(
   parameter int EW = 8,
   localparam int PW = 2 * EW + 2
) (
   input  logic                 uns,
   input  logic [EW-1:0]        a,
   input  logic [EW-1:0]        b,
   output logic signed [PW-1:0] prod
);
   logic signed [EW:0] ax;
   logic signed [EW:0] bx;

   always_comb begin
      ax = uns ? {1'b0, a} : {a[EW-1], a};
      bx = uns ? {1'b0, b} : {b[EW-1], b};
   end

   assign prod = ax * bx;
endmodule

// File: rtl/dp_lane.sv
module dp_lane #(
   parameter int EW       = 8,
   parameter int NE       = 4,
   parameter int LW       = 32,
   parameter bit PAIR_SUM = 1'b1,
   localparam int PW = 2 * EW + 2,
   localparam int SW = PW + dp_pkg::dp_log2up(NE)
) (
   input  logic             uns,
   input  logic [NE*EW-1:0] a,
   input  logic [NE*EW-1:0] b,
   input  logic [LW-1:0]    acc,
   output logic [LW-1:0]    sum_out
);
   initial begin
      assert (LW > SW) else $error("dp_lane: lane too narrow for dot sum");
      assert (!PAIR_SUM || (NE % 2 == 0)) else $error("dp_lane: pair sum needs even count");
   end

   logic signed [PW-1:0] prod [NE];
   logic signed [SW-1:0] dot;

   for (genvar i = 0; i < NE; i++) begin : g_mul
      dp_elem_mul #(.EW(EW)) u_mul (
         .uns  (uns),
         .a    (a[i*EW +: EW]),
         .b    (b[i*EW +: EW]),
         .prod (prod[i])
      );
   end

   if (PAIR_SUM) begin : g_pair
      localparam int NP = NE / 2;
      logic signed [PW:0] pair [NP];
      for (genvar p = 0; p < NP; p++) begin : g_p
         assign pair[p] = {prod[2*p][PW-1], prod[2*p]} + {prod[2*p+1][PW-1], prod[2*p+1]};
      end
      always_comb begin
         dot = '0;
         for (int p = 0; p < NP; p++) begin
            dot = dot + {{(SW-PW-1){pair[p][PW]}}, pair[p]};
         end
      end
   end else begin : g_chain
      always_comb begin
         dot = '0;
         for (int i = 0; i < NE; i++) begin
            dot = dot + {{(SW-PW){prod[i][PW-1]}}, prod[i]};
         end
      end
   end

   assign sum_out = acc + {{(LW-SW){dot[SW-1]}}, dot};
endmodule

// File: rtl/dp_legal.sv
module dp_legal (
   input  logic                wide,
   input  dp_pkg::dp_idx_lsb_t idx,
   output logic                bad
);
   assign bad = wide & (idx.dst | idx.srca | idx.srcb);
endmodule

// File: rtl/byte_dot_acc.sv
module byte_dot_acc #(
   parameter int ELEM_W    = 8,
   parameter int ELEMS     = 4,
   parameter int HALF_W    = 64,
   parameter int HALVES    = 2,
   parameter bit PAIR_SUM  = 1'b1,
   localparam int LANE_W   = ELEM_W * ELEMS,
   localparam int LPH      = HALF_W / LANE_W,
   localparam int LANES    = LPH * HALVES,
   localparam int VEC_W    = HALF_W * HALVES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             is_unsigned,
   input  logic             wide_mode,
   input  logic             dst_idx_lsb,
   input  logic             srca_idx_lsb,
   input  logic             srcb_idx_lsb,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] acc_in,
   output logic             out_valid,
   output logic             illegal,
   output logic [VEC_W-1:0] result
);
   initial begin
      assert (HALF_W % LANE_W == 0) else $error("byte_dot_acc: half not a lane multiple");
      assert (HALVES == 2) else $error("byte_dot_acc: two halves expected");
   end

   dp_pkg::dp_idx_lsb_t idx;
   logic                bad_c;
   logic [VEC_W-1:0]    next_c;

   assign idx = '{dst: dst_idx_lsb, srca: srca_idx_lsb, srcb: srcb_idx_lsb};

   dp_legal u_legal (
      .wide (wide_mode),
      .idx  (idx),
      .bad  (bad_c)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] lane_sum;
      dp_lane #(.EW(ELEM_W), .NE(ELEMS), .LW(LANE_W), .PAIR_SUM(PAIR_SUM)) u_lane (
         .uns     (is_unsigned),
         .a       (src_a[l*LANE_W +: LANE_W]),
         .b       (src_b[l*LANE_W +: LANE_W]),
         .acc     (acc_in[l*LANE_W +: LANE_W]),
         .sum_out (lane_sum)
      );
      if (l < LPH) begin : g_low
         assign next_c[l*LANE_W +: LANE_W] = lane_sum;
      end else begin : g_high
         assign next_c[l*LANE_W +: LANE_W] = wide_mode ? lane_sum : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid & ~bad_c;
         illegal   <= in_valid & bad_c;
         if (in_valid && !bad_c) result <= next_c;
      end
   end

   assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !out_valid);
   assert_hold_on_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $stable(result));
   assert_odd_index_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wide_mode && (dst_idx_lsb || srca_idx_lsb || srcb_idx_lsb)) |=> illegal);
   assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide_mode) |=> (out_valid && result[VEC_W-1:HALF_W] == '0));
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !illegal && $stable(result)));
   assert_narrow_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide_mode) |=> !illegal);
endmodule

// File: tb/sim_byte_dot_acc.sv
`timescale 1ns/1ps
module sim_byte_dot_acc;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0, is_unsigned = 1'b0, wide_mode = 1'b0;
   logic         dst_idx_lsb = 1'b0, srca_idx_lsb = 1'b0, srcb_idx_lsb = 1'b0;
   logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
   logic         out_valid, illegal;
   logic [127:0] result;

   int total = 0;
   int bad   = 0;
   logic [127:0] last_res = '0;

   always #4 clk = ~clk;

   byte_dot_acc u0 (.*);

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input logic [127:0] c, input logic u, input logic w);
      logic [127:0] r;
      r = '0;
      for (int l = 0; l < 4; l++) begin
         int s;
         s = 0;
         if (l >= 2 && !w) continue;
         for (int k = 0; k < 4; k++) begin
            logic [7:0] x, y;
            int xi, yi;
            x = a[(4*l+k)*8 +: 8];
            y = b[(4*l+k)*8 +: 8];
            xi = u ? int'(x) : int'($signed(x));
            yi = u ? int'(y) : int'($signed(y));
            s = s + xi * yi;
         end
         r[l*32 +: 32] = c[l*32 +: 32] + 32'(s);
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                      input logic u, input logic w, input logic [2:0] lsb, input string tag);
      logic [127:0] e;
      logic ill;
      ill = w && (lsb != 3'b000);
      e = ill ? last_res : model(a, b, c, u, w);
      @(negedge clk);
      src_a = a; src_b = b; acc_in = c; is_unsigned = u; wide_mode = w;
      {dst_idx_lsb, srca_idx_lsb, srcb_idx_lsb} = lsb;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(result == e, tag, result, e);
      chk(out_valid == !ill && illegal == ill, {tag, " flags"}, {126'd0, out_valid, illegal}, {126'd0, !ill, ill});
      last_res = result;
   endtask

   initial begin
      #1200000;
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!out_valid && !illegal && result == '0, "R10 reset", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !illegal && result == '0, "R10 after reset", result, '0);

      // R1 R2 R3 R4 R5: sweep every first-source byte against a stride of second-source bytes
      for (int u = 0; u < 2; u++) begin
         for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y += 17) begin
               logic [127:0] a, b, c;
               for (int k = 0; k < 16; k++) begin
                  a[k*8 +: 8] = 8'(x + 37 * (k % 4) * (k / 4)) ^ ((k % 4 == 1) ? 8'hFF : 8'h00);
                  b[k*8 +: 8] = 8'(y * (k + 1)) ^ ((k % 4 == 2) ? 8'h80 : 8'h00);
               end
               c = {32'(x * 977 + y), 32'hFFFF_FF00 + 32'(y), 32'h7FFF_FF80 + 32'(x), 32'(x * y)};
               run(a, b, c, u[0], x[0] ^ y[0], 3'b000, "R1 R2 R3 R4 R5 sweep");
            end
         end
      end

      // R2 R3: corner bytes on accumulators near 2^31 and 2^32
      run({16{8'h80}}, {16{8'h80}}, {4{32'h7FFF_FFFF}}, 1'b0, 1'b1, 3'b000, "R2 R3 signed 0x80");
      run({16{8'h80}}, {16{8'h80}}, {4{32'hFFFF_FFFF}}, 1'b1, 1'b1, 3'b000, "R2 R3 unsigned 0x80");
      run({16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFFF}}, 1'b0, 1'b1, 3'b000, "R2 R3 signed 0xFF");
      run({16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFFF}}, 1'b1, 1'b1, 3'b000, "R2 R3 unsigned 0xFF wrap");
      run({16{8'h80}}, {16{8'h7F}}, {4{32'h8000_0000}}, 1'b0, 1'b1, 3'b000, "R2 R3 signed min x max");
      run({16{8'hFF}}, {16{8'hFF}}, {4{32'h7FFF_FFFF}}, 1'b1, 1'b0, 3'b000, "R3 R4 narrow wrap");

      // R6 R7 R9: every index-bit combination in both widths
      for (int w = 0; w < 2; w++) begin
         for (int m = 0; m < 8; m++) begin
            run({16{8'h12}} ^ 128'(m), {16{8'h34}}, {4{32'(m)}}, 1'b1, w[0], 3'(m), "R6 R7 R9 legality");
         end
      end
      // R7 back-to-back refused requests keep the earlier result
      run({16{8'h01}}, {16{8'h02}}, {4{32'h10}}, 1'b0, 1'b1, 3'b000, "R5 setup");
      run({16{8'hAA}}, {16{8'h55}}, {4{32'h20}}, 1'b0, 1'b1, 3'b100, "R7 refused dst");
      run({16{8'hAA}}, {16{8'h55}}, {4{32'h20}}, 1'b0, 1'b1, 3'b001, "R7 refused srcb");

      // R8: idle cycles keep everything quiet
      src_a = '1; src_b = '1; acc_in = '1;
      repeat (3) begin
         @(negedge clk);
         chk(!out_valid && !illegal && result == last_res, "R8 idle", result, last_res);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule